// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block serializes stereo audio for a serial audio link. Each input word is 32 bits wide and holds two 16-bit samples. The low half is the left sample and the high half is the right sample. The block shifts these samples out, MSB first, on a single data line. It also drives the word-select / frame-sync line. Timing comes from an external clock generator, which supplies two strobes in the system clock domain. `bit_tick_i` is high for one system clock per bit-clock period and marks the falling bit-clock edge, where the line data changes. `frame_tick_i` is given together with a bit tick to mark the first slot of a 64-slot frame.

Configuration inputs select the framing. The I2S family has three justifications: standard (MSB one slot after the word-select edge), left-justified and right-justified. There is also a short-pulse PCM mode in which the first data bit follows the one-slot sync pulse by 0 to 3 bit clocks. A width field gives the number of bits sent per sample. A new word is taken at every frame boundary. If none is offered, the frame carries zeros and an underrun pulse is raised.

Top module: `aud_serial_tx`

## Requirements
- R1: After reset `sdata_o`, `ws_o`, `underrun_o` and `in_ready_o` are 0. All of them stay 0, whatever `in_valid_i` does, until the first bit tick that comes with `frame_tick_i`.
- R2: A frame is 64 slots, and each bit tick starts the next slot. A bit tick with `frame_tick_i` starts slot 0. Without a marker, slot 63 wraps to slot 0. `sdata_o` and `ws_o` change only on the clock edge where `bit_tick_i` is high.
- R3: `in_ready_o` is high only in the cycle where a bit tick starts slot 0. The word is taken if `in_valid_i` is also high. Bits [15:0] are the left sample and bits [31:16] are the right sample, both sent MSB first.
- R4: With `cfg_pcm_i`=0 and `cfg_just_i`=0 (standard), `ws_o` is 0 in slots 0–31 and 1 in slots 32–63. The left MSB is in slot 1 and the right MSB is in slot 33.
- R5: With `cfg_just_i`=1 (left-justified), `ws_o` is the same as in R4. The left MSB is in slot 0 and the right MSB is in slot 32.
- R6: With `cfg_just_i`=2 (right-justified), the last sent bit of the left sample is in slot 31 and that of the right sample is in slot 63.
- R7: `cfg_just_i`=3 behaves exactly like standard mode.
- R8: With `cfg_pcm_i`=1, `ws_o` is high in slot 0 only. The left sample starts in slot d (d = `cfg_delay_i`, 0..3), and the right sample follows directly at slot d+W.
- R9: `cfg_width_i` holds W−1. Each sample sends its top W bits. Every slot outside the data positions carries 0.
- R10: If `in_valid_i` is low when slot 0 starts, the whole frame carries zero data and `ws_o` keeps its normal waveform. `underrun_o` is high for exactly one clock, the one after that edge.
- R11: The configuration inputs are captured at the start of slot 0. Changing them mid-frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick_i | input | 1 | One-cycle strobe per bit clock (falling edge) |
| frame_tick_i | input | 1 | Frame-start marker, qualified by bit_tick_i |
| cfg_just_i | input | 2 | Justification: 0 standard, 1 left, 2 right, 3 as 0 |
| cfg_pcm_i | input | 1 | 1 selects short-pulse PCM framing |
| cfg_delay_i | input | 2 | PCM data delay in bit clocks |
| cfg_width_i | input | 4 | Sample width minus one |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Word accepted this cycle if valid |
| in_data_i | input | 32 | Packed right (high) / left (low) samples |
| sdata_o | output | 1 | Serial data line |
| ws_o | output | 1 | Word-select or frame-sync line |
| underrun_o | output | 1 | One-clock pulse when a frame starts without data |

## Verification
The hardest condition to reach is a configuration change in the middle of a frame. It has to arrive after the frame has begun and still leave the frame's waveform untouched. The bench reaches it by changing every configuration input at slot 5 of selected frames, and it predicts each slot from the settings in force at slot 0. A second hard condition is a boundary reached only by counter wrap, with no marker. Some frames are therefore run without `frame_tick_i`, and the bench checks that a word is still taken. Random frames mix modes, delays, widths and missing words.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int HALF_SLOTS = 32;
  localparam int WIDTH_W    = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    JUST_STD   = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_RIGHT = 2'd2,
    JUST_RSVD  = 2'd3
  } just_e;

  typedef struct packed {
    just_e              just;
    logic               pcm;
    logic [1:0]         dly;
    logic [WIDTH_W-1:0] width_m1;
  } tx_cfg_t;
endpackage

// File: rtl/aud_tx_slot_timer.sv
module aud_tx_slot_timer #(
  parameter int FRAME_SLOTS = 64,
  parameter int CNT_W       = $clog2(FRAME_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick_i,
  input  logic             frame_tick_i,
  output logic [CNT_W-1:0] slot_next_o,
  output logic             advance_o,
  output logic             at_frame_o,
  output logic             running_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_SLOTS - 1);

  logic [CNT_W-1:0] slot_q;
  logic             run_q;

  always_comb begin
    if (frame_tick_i || slot_q == LAST) slot_next_o = '0;
    else                                slot_next_o = slot_q + 1'b1;
  end

  assign advance_o  = bit_tick_i && (run_q || frame_tick_i);
  assign at_frame_o = advance_o && (slot_next_o == '0);
  assign running_o  = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (bit_tick_i && frame_tick_i) run_q <= 1'b1;
      if (advance_o) slot_q <= slot_next_o;
    end
  end

  AST_SLOT_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !bit_tick_i |=> $stable(slot_q)); // R2
endmodule

// File: rtl/aud_tx_word_stage.sv
module aud_tx_word_stage
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W = aud_tx_pkg::SAMPLE_W,
  parameter int WORD_W   = 2 * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              at_frame_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  input  tx_cfg_t           cfg_i,
  output logic [WORD_W-1:0] word_o,
  output tx_cfg_t           cfg_o,
  output logic              starve_o
);
  logic [WORD_W-1:0] wd_q;
  tx_cfg_t           cfg_q;
  logic [WORD_W-1:0] fresh;

  assign fresh    = in_valid_i ? in_data_i : '0;
  assign starve_o = at_frame_i && !in_valid_i;
  assign word_o   = at_frame_i ? fresh : wd_q;
  assign cfg_o    = at_frame_i ? cfg_i : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q  <= '0;
      cfg_q <= '0;
    end else if (at_frame_i) begin
      wd_q  <= fresh;
      cfg_q <= cfg_i;
    end
  end

  AST_FRAME_STATE_HELD: assert property (@(posedge clk) disable iff (rst)
    !at_frame_i |=> ($stable(wd_q) && $stable(cfg_q))); // R11
endmodule

// File: rtl/aud_tx_bit_map.sv
module aud_tx_bit_map
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W   = aud_tx_pkg::SAMPLE_W,
  parameter int HALF_SLOTS = aud_tx_pkg::HALF_SLOTS,
  parameter int CNT_W      = $clog2(2 * HALF_SLOTS),
  parameter int WORD_W     = 2 * SAMPLE_W
) (
  input  logic [CNT_W-1:0]  slot_i,
  input  logic [WORD_W-1:0] word_i,
  input  tx_cfg_t           cfg_i,
  output logic              bit_o,
  output logic              ws_o
);
  localparam int IDX_W = $clog2(WORD_W);

  int               s_v, w_v, rel_v, pos_v, start_v;
  logic             upper_v;
  logic [IDX_W-1:0] idx_v;

  always_comb begin
    bit_o   = 1'b0;
    ws_o    = 1'b0;
    s_v     = int'(slot_i);
    w_v     = int'(cfg_i.width_m1) + 1;
    rel_v   = 0;
    pos_v   = 0;
    start_v = 0;
    upper_v = 1'b0;
    idx_v   = '0;
    if (cfg_i.pcm) begin
      ws_o  = (s_v == 0);
      rel_v = s_v - int'(cfg_i.dly);
      if (rel_v >= 0 && rel_v < w_v) begin
        idx_v = IDX_W'(SAMPLE_W - 1 - rel_v);
        bit_o = word_i[idx_v];
      end else if (rel_v >= w_v && rel_v < 2 * w_v) begin
        idx_v = IDX_W'(WORD_W - 1 - (rel_v - w_v));
        bit_o = word_i[idx_v];
      end
    end else begin
      upper_v = (s_v >= HALF_SLOTS);
      ws_o    = upper_v;
      pos_v   = upper_v ? s_v - HALF_SLOTS : s_v;
      case (cfg_i.just)
        JUST_LEFT:  start_v = 0;
        JUST_RIGHT: start_v = HALF_SLOTS - w_v;
        default:    start_v = 1;
      endcase
      rel_v = pos_v - start_v;
      if (rel_v >= 0 && rel_v < w_v) begin
        idx_v = upper_v ? IDX_W'(WORD_W - 1 - rel_v) : IDX_W'(SAMPLE_W - 1 - rel_v);
        bit_o = word_i[idx_v];
      end
    end
  end
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W   = aud_tx_pkg::SAMPLE_W,
  parameter int HALF_SLOTS = aud_tx_pkg::HALF_SLOTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_tick_i,
  input  logic                  frame_tick_i,
  input  logic [1:0]            cfg_just_i,
  input  logic                  cfg_pcm_i,
  input  logic [1:0]            cfg_delay_i,
  input  logic [WIDTH_W-1:0]    cfg_width_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [2*SAMPLE_W-1:0] in_data_i,
  output logic                  sdata_o,
  output logic                  ws_o,
  output logic                  underrun_o
);
  localparam int FRAME_SLOTS = 2 * HALF_SLOTS;
  localparam int CNT_W       = $clog2(FRAME_SLOTS);
  localparam int WORD_W      = 2 * SAMPLE_W;

  logic [CNT_W-1:0]  slot_next;
  logic              advance, at_frame, running, starve;
  logic [WORD_W-1:0] cur_word;
  tx_cfg_t           cfg_in, cur_cfg;
  logic              nxt_bit, nxt_ws;
  logic              sd_q, ws_q, urun_q;

  assign cfg_in.just     = just_e'(cfg_just_i);
  assign cfg_in.pcm      = cfg_pcm_i;
  assign cfg_in.dly      = cfg_delay_i;
  assign cfg_in.width_m1 = cfg_width_i;

  aud_tx_slot_timer #(.FRAME_SLOTS(FRAME_SLOTS), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .bit_tick_i(bit_tick_i), .frame_tick_i(frame_tick_i),
    .slot_next_o(slot_next), .advance_o(advance), .at_frame_o(at_frame),
    .running_o(running));

  aud_tx_word_stage #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) words_i (
    .clk(clk), .rst(rst), .at_frame_i(at_frame), .in_valid_i(in_valid_i),
    .in_data_i(in_data_i), .cfg_i(cfg_in), .word_o(cur_word), .cfg_o(cur_cfg),
    .starve_o(starve));

  aud_tx_bit_map #(.SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS), .CNT_W(CNT_W),
                   .WORD_W(WORD_W)) map_i (
    .slot_i(slot_next), .word_i(cur_word), .cfg_i(cur_cfg),
    .bit_o(nxt_bit), .ws_o(nxt_ws));

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q   <= 1'b0;
      ws_q   <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      urun_q <= starve;
      if (advance) begin
        sd_q <= nxt_bit;
        ws_q <= nxt_ws;
      end
    end
  end

  assign in_ready_o = at_frame;
  assign sdata_o    = sd_q;
  assign ws_o       = ws_q;
  assign underrun_o = urun_q;

  AST_IDLE_UNTIL_MARKER: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!sdata_o && !ws_o && !underrun_o)); // R1
  AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_tick_i) |-> ($stable(sdata_o) && $stable(ws_o))); // R2
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    in_ready_o |-> bit_tick_i); // R3
  AST_UNDERRUN_SILENT: assert property (@(posedge clk) disable iff (rst)
    underrun_o |-> !sdata_o); // R10
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> !underrun_o); // R10
endmodule

// File: tb/aud_serial_tx_tb_top.sv
`timescale 1ns/1ps
module aud_serial_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0, frame_tick = 1'b0;
  logic [1:0]  cfg_just = 2'd0;
  logic        cfg_pcm = 1'b0;
  logic [1:0]  cfg_delay = 2'd0;
  logic [3:0]  cfg_width = 4'd15;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        sdata, ws, underrun;

  int n_run = 0;
  int n_fail = 0;
  bit started = 1'b0;

  always #4 clk = ~clk;

  aud_serial_tx dut_i (
    .clk(clk), .rst(rst), .bit_tick_i(bit_tick), .frame_tick_i(frame_tick),
    .cfg_just_i(cfg_just), .cfg_pcm_i(cfg_pcm), .cfg_delay_i(cfg_delay),
    .cfg_width_i(cfg_width), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .sdata_o(sdata), .ws_o(ws), .underrun_o(underrun));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_sd(int s, logic [31:0] w, logic [1:0] just,
                                bit pcm, int d, int wd);
    int l0, r0, off;
    if (pcm) begin
      l0 = d;
      r0 = d + wd;
    end else begin
      off = (just == 2'd1) ? 0 : (just == 2'd2) ? 32 - wd : 1;
      l0 = off;
      r0 = 32 + off;
    end
    if (s >= l0 && s < l0 + wd) return w[15 - (s - l0)];
    if (s >= r0 && s < r0 + wd) return w[31 - (s - r0)];
    return 1'b0;
  endfunction

  function automatic bit exp_ws(int s, bit pcm);
    return pcm ? (s == 0) : (s >= 32);
  endfunction

  task automatic run_frame(input logic [31:0] w, input bit vld, input logic [1:0] just,
                           input bit pcm, input logic [1:0] dly, input logic [3:0] wm1,
                           input bit marker, input bit mid);
    string tag;
    logic [31:0] ew;
    bit hs, hw;
    ew = vld ? w : 32'd0;
    if (!vld) tag = "R10";
    else if (mid) tag = "R11";
    else if (wm1 != 4'd15) tag = "R9";
    else if (pcm) tag = "R8";
    else if (just == 2'd1) tag = "R5";
    else if (just == 2'd2) tag = "R6";
    else if (just == 2'd3) tag = "R7";
    else tag = "R4";
    @(negedge clk);
    cfg_just = just; cfg_pcm = pcm; cfg_delay = dly; cfg_width = wm1;
    for (int s = 0; s < 64; s++) begin
      @(negedge clk);
      bit_tick = 1'b1;
      frame_tick = marker && (s == 0);
      in_valid = vld && (s == 0);
      in_data = w;
      if (mid && s == 5) begin
        cfg_pcm = ~pcm; cfg_just = just + 2'd1; cfg_delay = dly + 2'd1;
        cfg_width = wm1 - 4'd4;
      end
      #1;
      check(in_ready == ((s == 0) && (marker || started)), "R3", "in_ready",
            int'(in_ready), int'((s == 0) && (marker || started)));
      @(negedge clk);
      bit_tick = 1'b0; frame_tick = 1'b0; in_valid = 1'b0;
      if (marker) started = 1'b1;
      check(sdata == exp_sd(s, ew, just, pcm, int'(dly), int'(wm1) + 1), tag,
            $sformatf("sdata slot %0d", s), int'(sdata),
            int'(exp_sd(s, ew, just, pcm, int'(dly), int'(wm1) + 1)));
      check(ws == exp_ws(s, pcm), tag, $sformatf("ws slot %0d", s), int'(ws),
            int'(exp_ws(s, pcm)));
      if (s == 0 || !vld)
        check(underrun == (!vld && s == 0), "R10", "underrun", int'(underrun),
              int'(!vld && s == 0));
      hs = sdata; hw = ws;
      @(negedge clk);
      check(sdata == hs && ws == hw, "R2", "hold between ticks", int'({sdata, ws}),
            int'({hs, hw}));
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({sdata, ws, underrun, in_ready} == 4'b0, "R1", "reset outputs",
          int'({sdata, ws, underrun, in_ready}), 0);
    // R1: ticks and valid data before the first marker are ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bit_tick = 1'b1; in_valid = 1'b1; in_data = 32'hFFFF_FFFF;
      #1;
      check(!in_ready, "R1", "ready before marker", int'(in_ready), 0);
      @(negedge clk);
      bit_tick = 1'b0; in_valid = 1'b0;
      check({sdata, ws, underrun} == 3'b0, "R1", "idle before marker",
            int'({sdata, ws, underrun}), 0);
    end
    run_frame(32'hA5C3_5A3C, 1, 2'd0, 0, 2'd0, 4'd15, 1, 0);
    run_frame(32'h8001_7FFE, 1, 2'd1, 0, 2'd0, 4'd15, 1, 0);
    run_frame(32'h1234_CDEF, 1, 2'd2, 0, 2'd0, 4'd15, 0, 0);
    run_frame(32'hF00F_0FF0, 1, 2'd3, 0, 2'd0, 4'd15, 1, 0);
    for (int d = 0; d < 4; d++)
      run_frame(32'h9A5B_C3E1 ^ (32'h1111 * d), 1, 2'd0, 1, 2'(d), 4'd15, 1, 0);
    run_frame(32'hFFFF_FFFF, 1, 2'd0, 0, 2'd0, 4'd7, 1, 0);
    run_frame(32'hBEEF_CAFE, 1, 2'd2, 0, 2'd0, 4'd11, 1, 0);
    run_frame(32'hFFFF_FFFF, 1, 2'd0, 1, 2'd2, 4'd3, 1, 0);
    run_frame(32'hFFFF_FFFF, 0, 2'd0, 0, 2'd0, 4'd15, 1, 0);
    run_frame(32'hFFFF_FFFF, 0, 2'd0, 1, 2'd0, 4'd15, 0, 0);
    run_frame(32'h6C3A_95D2, 1, 2'd0, 0, 2'd0, 4'd15, 1, 1);
    run_frame(32'h6C3A_95D2, 1, 2'd2, 1, 2'd3, 4'd15, 1, 1);
    for (int i = 0; i < 30; i++) begin
      logic [31:0] rw;
      logic [1:0]  rj, rd;
      logic [3:0]  rwm;
      bit rp, rv, rm, rk;
      rw  = $urandom;
      rj  = 2'($urandom % 4);
      rd  = 2'($urandom % 4);
      rwm = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'd15;
      rp  = ($urandom % 3) == 0;
      rv  = ($urandom % 8) != 0;
      rm  = ($urandom % 5) != 0;
      rk  = ($urandom % 6) == 0;
      run_frame(rw, rv, rj, rp, rd, rwm, rm, rk);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule